// File: doc/BRIEF.md
# UART Receive Status and FIFO

This block sits behind a UART receive deserializer. Each time the deserializer finishes a character it presents the byte for one clock with three per-character flags: parity error, framing error and break. The block queues the byte together with its flags in a receive FIFO. The CPU sees the head byte and a line status register through a small register bus. A receiver line status interrupt is driven when an error indication is pending and the enable bit allows it.

A character's error flags stay with it through the FIFO. They reach the status register only when that character becomes the head entry. A character that arrives while the FIFO is full is dropped, and the overrun indication is raised straight away. The break, framing, parity and overrun bits are sticky. A CPU read of the status register clears them, unless a new error event lands in the same clock.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the FIFO is empty, the status register reads 0x00, `data_ready` and `rls_irq` are 0, and the interrupt enable register reads 0x00.
- R2: Status bit 0 and `data_ready` are 1 exactly when the FIFO holds at least one character. A read at address 0 returns the head byte, or 0x00 when the FIFO is empty. When the FIFO is not empty, that read pops one entry at the clock edge.
- R3: The break, framing and parity flags are stored with their character. When a character becomes the head entry, each of its set flags sets the matching status bit in the next cycle: break at bit 4, framing at bit 3, parity at bit 2.
- R4: A character that arrives while 16 entries are held and no pop happens in the same cycle is discarded. The FIFO contents are unchanged, and status bit 1 (overrun) reads 1 in the next cycle.
- R5: A character that arrives while the FIFO is full, in the same cycle as a pop, is accepted and no overrun is flagged.
- R6: A read at address 5 (line status) clears bits 4 to 1 at the clock edge. If an event that sets one of these bits occurs in the same cycle, that bit stays 1.
- R7: `rls_irq` is 1 exactly when bit 2 of the interrupt enable register (address 1, writable) is 1 and any of status bits 4 to 1 is 1.
- R8: A write to address 5 or to address 0 changes no state.
- R9: Status bits 7 to 5 always read 0, and reads of addresses other than 0, 1 and 5 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Received byte |
| char_pe | input | 1 | Character had a bad parity bit |
| char_fe | input | 1 | Character had a framing error |
| char_brk | input | 1 | Character was a break |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| data_ready | output | 1 | FIFO not empty |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
Two corner cases are the hardest to reach from the ports. The first is a FIFO held at exactly 16 entries while a new character arrives, both with and without a pop in that same cycle. The bench fills the FIFO with no reads, then drives the extra character alone, and later drives it together with a data read. The second is a status read that lands in the same cycle as a character with a flag reaching the head of an empty FIFO. The bench aims that combination directly. A long random phase then biases read and write rates so that the FIFO often sits near full while flags and status reads land in arbitrary cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int RX_DATA_W = 8;
    localparam int RX_ADDR_W = 3;

    localparam logic [RX_ADDR_W-1:0] ADDR_RXDATA = 3'd0;
    localparam logic [RX_ADDR_W-1:0] ADDR_IRQEN  = 3'd1;
    localparam logic [RX_ADDR_W-1:0] ADDR_LSTAT  = 3'd5;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t              flags;
        logic [RX_DATA_W-1:0]   data;
    } rx_entry_t;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
        logic oe;
    } err_bits_t;

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  rx_entry_t                  wr_entry,
    output logic [RX_DATA_W-1:0]       head_data,
    output logic                       full,
    output logic                       empty,
    output logic                       head_load,
    output rx_flags_t                  head_next_flags
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    rx_entry_t   mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (st_q.count == CNT_W'(DEPTH));
    assign empty     = (st_q.count == '0);
    assign head_data = mem_q[st_q.rd_ptr].data;

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        unique case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        // a new entry takes the head: first arrival, or a pop that leaves something
        head_load = (push && empty) || (pop && (st_q.count > CNT_W'(1) || push));
        if (pop && st_q.count > CNT_W'(1))
            head_next_flags = mem_q[ptr_inc(st_q.rd_ptr)].flags;
        else
            head_next_flags = wr_entry.flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr_ptr] <= wr_entry;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R4
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !push);

    // R2
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

    // R2
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.count == $past(st_q.count) + 1'b1));

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      head_load,
    input  rx_flags_t head_flags,
    input  logic      ovr_evt,
    input  logic      lsr_rd,
    output err_bits_t err_q
);
    err_bits_t err_d;

    always_comb begin
        err_d = lsr_rd ? '0 : err_q;
        if (head_load) begin
            err_d.brk = err_d.brk | head_flags.brk;
            err_d.fe  = err_d.fe  | head_flags.fe;
            err_d.pe  = err_d.pe  | head_flags.pe;
        end
        if (ovr_evt) err_d.oe = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    // R6
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !head_load && !ovr_evt) |=> (err_q == '0));

    // R4
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> err_q.oe);

    // R3
    pe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_load && head_flags.pe) |=> err_q.pe);

    // R6
    no_spurious_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_evt && !err_q.oe) |=> !err_q.oe);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int IRQ_EN_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  char_valid,
    input  logic [RX_DATA_W-1:0]  char_data,
    input  logic                  char_pe,
    input  logic                  char_fe,
    input  logic                  char_brk,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [RX_ADDR_W-1:0]  bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  data_ready,
    output logic                  rls_irq
);
    typedef struct packed {
        logic [7:0] irq_en;
    } top_state_t;

    top_state_t st_q, st_d;

    logic                 rd_data, rd_lsr, wr_irqen;
    logic                 push, pop, ovr_evt;
    logic                 full, empty, head_load;
    logic [RX_DATA_W-1:0] head_data;
    rx_flags_t            head_flags;
    rx_entry_t            in_entry;
    err_bits_t            err_q;
    logic [7:0]           lsr_val;

    assign rd_data   = bus_en && !bus_we && (bus_addr == ADDR_RXDATA);
    assign rd_lsr    = bus_en && !bus_we && (bus_addr == ADDR_LSTAT);
    assign wr_irqen  = bus_en &&  bus_we && (bus_addr == ADDR_IRQEN);

    assign pop       = rd_data && !empty;
    assign push      = char_valid && (!full || pop);
    assign ovr_evt   = char_valid && full && !pop;

    assign in_entry.data      = char_data;
    assign in_entry.flags.pe  = char_pe;
    assign in_entry.flags.fe  = char_fe;
    assign in_entry.flags.brk = char_brk;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk             (clk),
        .rst_n           (rst_n),
        .push            (push),
        .pop             (pop),
        .wr_entry        (in_entry),
        .head_data       (head_data),
        .full            (full),
        .empty           (empty),
        .head_load       (head_load),
        .head_next_flags (head_flags)
    );

    uart_rx_lsr u_lsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_load  (head_load),
        .head_flags (head_flags),
        .ovr_evt    (ovr_evt),
        .lsr_rd     (rd_lsr),
        .err_q      (err_q)
    );

    always_comb begin
        st_d = st_q;
        if (wr_irqen) st_d.irq_en = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lsr_val    = {3'b000, err_q.brk, err_q.fe, err_q.pe, err_q.oe, !empty};
    assign data_ready = !empty;
    assign rls_irq    = st_q.irq_en[IRQ_EN_BIT] && (err_q != '0);

    always_comb begin
        unique case (bus_addr)
            ADDR_RXDATA: bus_rdata = empty ? 8'h00 : 8'(head_data);
            ADDR_IRQEN:  bus_rdata = st_q.irq_en;
            ADDR_LSTAT:  bus_rdata = lsr_val;
            default:     bus_rdata = 8'h00;
        endcase
    end

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq_en[IRQ_EN_BIT] |-> !rls_irq);

    // R6
    irq_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !head_load && !ovr_evt) |=> !rls_irq);

    // R2
    ready_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> data_ready);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_LSTAT) |-> (bus_rdata[7:5] == 3'b000));

endmodule

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;

    localparam int DEPTH = 16;
    localparam int MAX_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_pe = 1'b0, char_fe = 1'b0, char_brk = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       data_ready, rls_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_rx_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .char_valid(char_valid), .char_data(char_data),
        .char_pe(char_pe), .char_fe(char_fe), .char_brk(char_brk),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_ready(data_ready), .rls_irq(rls_irq)
    );

    // reference model: entry = {brk, fe, pe, data}
    logic [10:0] mq[$];
    logic        m_brk, m_fe, m_pe, m_oe;
    logic [7:0]  m_ier;
    int          m_osz;
    logic        m_pop, m_push, m_ovr, m_rd, m_head;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            {m_brk, m_fe, m_pe, m_oe} = '0;
            m_ier = '0;
        end else begin
            m_osz  = mq.size();
            m_pop  = bus_en && !bus_we && bus_addr == 3'd0 && m_osz > 0;
            m_rd   = bus_en && !bus_we && bus_addr == 3'd5;
            m_push = char_valid && (m_osz < DEPTH || m_pop);
            m_ovr  = char_valid && m_osz == DEPTH && !m_pop;
            if (m_pop)  void'(mq.pop_front());
            if (m_push) mq.push_back({char_brk, char_fe, char_pe, char_data});
            m_head = mq.size() > 0 && (m_pop || m_osz == 0);
            if (m_rd) {m_brk, m_fe, m_pe, m_oe} = '0;
            if (m_head) begin
                m_brk = m_brk | mq[0][10];
                m_fe  = m_fe  | mq[0][9];
                m_pe  = m_pe  | mq[0][8];
            end
            if (m_ovr) m_oe = 1'b1;
            if (bus_en && bus_we && bus_addr == 3'd1) m_ier = bus_wdata;
        end
    end

    function automatic logic [7:0] exp_lsr();
        return {3'b000, m_brk, m_fe, m_pe, m_oe, mq.size() > 0};
    endfunction

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            3'd0:    return (mq.size() > 0) ? mq[0][7:0] : 8'h00;
            3'd1:    return m_ier;
            3'd5:    return exp_lsr();
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 data_ready", {7'd0, data_ready}, {7'd0, mq.size() > 0});
        check("R7 rls_irq", {7'd0, rls_irq},
              {7'd0, m_ier[2] && (m_brk || m_fe || m_pe || m_oe)});
        check("R2 R3 R4 R6 R9 bus_rdata", bus_rdata, exp_rdata());
    endtask

    task automatic step(input logic en, input logic we, input logic [2:0] a,
                        input logic [7:0] wd, input logic cv, input logic [7:0] d,
                        input logic [2:0] flg);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
        char_valid = cv; char_data = d;
        char_pe = flg[0]; char_fe = flg[1]; char_brk = flg[2];
        #1;
        compare_all();
    endtask

    task automatic peek_lsr();
        step(1'b0, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", MAX_CYCLES, MAX_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [7:0] saved;

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        peek_lsr();
        check("R1 lsr after reset", bus_rdata, 8'h00);
        step(1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 8'h00, 3'b000);
        check("R1 irq enable after reset", bus_rdata, 8'h00);

        step(1'b1, 1'b1, 3'd1, 8'h04, 1'b0, 8'h00, 3'b000);
        // R3: flags travel with characters
        step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'hA5, 3'b001);
        step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'h3C, 3'b000);
        check("R3 parity bit on head", {7'd0, bus_rdata[2]}, 8'h01);
        step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'h81, 3'b110);
        check("R3 break/frame not yet at head", {6'd0, bus_rdata[4:3]}, 8'h00);
        check("R7 irq with pending parity", {7'd0, rls_irq}, 8'h01);
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);
        peek_lsr();
        check("R6 read clears error bits", {3'd0, bus_rdata[4:1], 1'b0}, 8'h00);
        check("R7 irq cleared", {7'd0, rls_irq}, 8'h00);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        check("R2 head byte", bus_rdata, 8'hA5);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        check("R2 second byte", bus_rdata, 8'h3C);
        peek_lsr();
        check("R3 break+frame at head", {6'd0, bus_rdata[4:3]}, 8'h03);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);

        // R6: status read coincides with a parity character reaching an empty head
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h42, 3'b001);
        peek_lsr();
        check("R6 new event wins over read", {7'd0, bus_rdata[2]}, 8'h01);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);

        // R8: writes to status and data addresses
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h11, 3'b100);
        peek_lsr();
        saved = bus_rdata;
        step(1'b1, 1'b1, 3'd5, 8'hFF, 1'b0, 8'h00, 3'b000);
        step(1'b1, 1'b1, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        peek_lsr();
        check("R8 status unchanged by write", bus_rdata, saved);
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        check("R8 data unchanged by write", bus_rdata, 8'h11);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);

        // R4: fill and overrun
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'(i + 8'h20), 3'b000);
        step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'hEE, 3'b000);
        peek_lsr();
        check("R4 overrun flagged", {7'd0, bus_rdata[1]}, 8'h01);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
            check("R4 contents kept", bus_rdata, 8'(i + 8'h20));
        end
        peek_lsr();
        check("R4 discarded char absent", {7'd0, bus_rdata[0]}, 8'h00);
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 8'h00, 3'b000);

        // R5: full with pop and push in the same cycle
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 8'(i + 8'h50), 3'b000);
        step(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h77, 3'b000);
        peek_lsr();
        check("R5 no overrun with pop", {7'd0, bus_rdata[1]}, 8'h00);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 3'b000);
            if (i == DEPTH - 1) check("R5 pushed char accepted", bus_rdata, 8'h77);
        end

        // R9: unmapped address and reserved bits
        step(1'b1, 1'b0, 3'd3, 8'h00, 1'b0, 8'h00, 3'b000);
        check("R9 unmapped reads zero", bus_rdata, 8'h00);

        // random phase with a varying read rate
        for (int i = 0; i < 6000; i++) begin
            automatic int rate = ((i / 500) % 2 == 0) ? 8 : 2;
            automatic logic en = ($urandom % rate) == 0;
            automatic logic [2:0] a;
            automatic int sel = $urandom % 8;
            a = (sel < 4) ? 3'd0 : (sel < 6) ? 3'd5 : (sel == 6) ? 3'd1 : 3'd3;
            step(en, ($urandom % 10) == 0, a,
                 (($urandom % 2) == 0) ? 8'h04 : 8'h00,
                 ($urandom % 3) == 0, 8'($urandom),
                 3'(($urandom % 4 == 0) ? $urandom : 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule